// File: doc/BRIEF.md
# Boot Console Register Bank

A slave register bank that boot firmware reaches over a simple memory-mapped bus. It reports system parameters, such as version, CPU count, clock rates, memory size and kernel addresses, and it takes service requests: a disk read, a character sent out, a character pulled in, and the launch of a secondary CPU. The configuration values come in on module inputs. They are captured while reset is held and stay frozen once reset is released.

Each bus request is taken in the cycle it is offered. Exactly one cycle later a response pulse comes back, carrying read data and an error flag. A write that commands something fires a one-cycle strobe in that same response cycle. The character input side is a valid/ready stream. The bank raises `cin_ready` combinationally only while a legal 64-bit read of the input-character register is being presented, and a character is consumed only when `cin_valid` and `cin_ready` are both high. The character output, disk and launch outputs carry no back-pressure. They are single-cycle strobes that the receiver must catch.

Register map (byte offset from the base): 0x00 last offset, 0x08 version, 0x10 CPU count, 0x18 boot CPU, 0x20 interrupt clock, 0x28 input char, 0x30 CPU MHz, 0x38 memory size, 0x40 kernel start, 0x48 kernel end, 0x50 entry point, 0x58 disk unit, 0x60 disk count, 0x68 disk address, 0x70 disk block, 0x78 disk op, 0x80 output char, 0x88 boot pointer. The bank is 144 bytes.

Top module: `bootcon_top`

## Requirements
- R1: Only `req_size` 4 or 8 is accepted. Any other size sets `rsp_err`, returns zero data, fires no strobe and changes no register.
- R2: After reset the disk unit reads 1, the last-offset register reads 143, and the boot CPU, disk count, address, block, op, output char and boot pointer registers read 0. The configuration inputs are captured during reset, and later changes to them are not seen.
- R3: A 4-byte read at a 4-aligned offset below 144 returns the low half of the 8-byte word at that offset when bit 2 is 0, and the high half when bit 2 is 1. A 4-byte read at 0x28 returns 0 and does not consume a character. Any other 4-byte read sets `rsp_err`.
- R4: An 8-byte read is legal only at an 8-aligned offset from 0x28 to 0x88. Any other offset sets `rsp_err`.
- R5: An 8-byte read at 0x28 raises `cin_ready` in the request cycle. It returns `cin_data` zero-extended when `cin_valid` is 1, and 0 when `cin_valid` is 0. No other access raises `cin_ready`.
- R6: Writing 0x13 to 0x78 pulses `disk_req` for one cycle, with the stored address, block and count on the disk outputs. Any other value sets `rsp_err` and is not stored.
- R7: A write to 0x80 pulses `cout_valid` for one cycle with `cout_data` equal to the low 8 bits of the write data. Those 8 bits read back zero-extended.
- R8: Writing an index from 1 to 2^CPU_W-1 to 0x18 pulses `launch_valid` with that index on `launch_cpu` and the stored boot pointer on `launch_ptr`. Zero or a larger value sets `rsp_err` and launches nothing.
- R9: Writes at offsets other than 0x18 and 0x58 to 0x88, and writes that are not 8-aligned, set `rsp_err` and change nothing.
- R10: `rsp_valid` is high for exactly one cycle, the cycle after each request. Every strobe appears in that response cycle.
- R11: A 4-byte write stores its low 32 bits zero-extended to 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; captures configuration inputs |
| cfg_version | input | 32 | Version value |
| cfg_cpu_count | input | 32 | Number of CPUs |
| cfg_intr_hz | input | 32 | Interrupt clock frequency |
| cfg_cpu_mhz | input | 64 | CPU clock in MHz |
| cfg_mem_size | input | 64 | Memory size |
| cfg_kern_start | input | 64 | Kernel start address |
| cfg_kern_end | input | 64 | Kernel end address |
| cfg_entry | input | 64 | Kernel entry point |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Byte address |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Fault on this access |
| rsp_rdata | output | 64 | Read data |
| cin_valid | input | 1 | Input character available |
| cin_data | input | 8 | Input character |
| cin_ready | output | 1 | Character consumed when high with cin_valid |
| cout_valid | output | 1 | Output character strobe |
| cout_data | output | 8 | Output character |
| disk_req | output | 1 | Disk read strobe |
| disk_paddr | output | 64 | Disk target address |
| disk_block | output | 64 | Disk block number |
| disk_count | output | 64 | Disk transfer count |
| launch_valid | output | 1 | CPU launch strobe |
| launch_cpu | output | CPU_W | CPU index to launch |
| launch_ptr | output | 64 | Startup pointer for that CPU |

## Verification
Two functions can meet in one cycle. The first case is a write to the disk address register followed in the very next cycle by the disk-op command: the strobe must carry the address just written. The bench issues those two requests back to back and compares the disk outputs in the second response cycle. The second case is an input character offered on `cin_valid` while a different register is being read. The bench holds `cin_valid` high across such reads and checks that `cin_ready` stays low, so the character is still there for the next read of the input register.

// File: rtl/bootcon_pkg.sv
package bootcon_pkg;
  localparam int unsigned NUM_REGS   = 18;
  localparam int unsigned BANK_BYTES = NUM_REGS * 8;
  localparam logic [63:0] DISK_RD_CODE = 64'h13;

  typedef enum logic [4:0] {
    IX_LAST    = 5'd0,
    IX_VER     = 5'd1,
    IX_NCPU    = 5'd2,
    IX_BOOTCPU = 5'd3,
    IX_INTR    = 5'd4,
    IX_CIN     = 5'd5,
    IX_MHZ     = 5'd6,
    IX_MEMSZ   = 5'd7,
    IX_KSTART  = 5'd8,
    IX_KEND    = 5'd9,
    IX_ENTRY   = 5'd10,
    IX_DUNIT   = 5'd11,
    IX_DCOUNT  = 5'd12,
    IX_DPADDR  = 5'd13,
    IX_DBLOCK  = 5'd14,
    IX_DOP     = 5'd15,
    IX_COUT    = 5'd16,
    IX_BPTR    = 5'd17
  } reg_ix_e;

  typedef struct packed {
    logic    legal;
    logic    rd64;
    logic    hi_half;
    logic    wide;
    reg_ix_e ix;
  } dec_t;
endpackage

// File: rtl/bootcon_decode.sv
module bootcon_decode
  import bootcon_pkg::*;
#(
  parameter int unsigned    AW   = 16,
  parameter logic [AW-1:0]  BASE = '0
) (
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [3:0]    req_size,
  output dec_t          dec
);
  localparam logic [AW-1:0] SPAN = AW'(BANK_BYTES);

  logic [AW-1:0] off;
  logic in_range, sz4, sz8, rd32, wr_ok, writable;

  always_comb begin
    off         = req_addr - BASE;
    in_range    = off < SPAN;
    sz4         = req_size == 4'd4;
    sz8         = req_size == 4'd8;
    dec.ix      = reg_ix_e'(off[7:3]);
    dec.wide    = sz8;
    dec.hi_half = off[2];
    case (dec.ix)
      IX_BOOTCPU, IX_DUNIT, IX_DCOUNT, IX_DPADDR,
      IX_DBLOCK, IX_DOP, IX_COUT, IX_BPTR: writable = 1'b1;
      default:                             writable = 1'b0;
    endcase
    dec.rd64  = sz8 && in_range && (off[2:0] == 3'd0) && (dec.ix >= IX_CIN);
    rd32      = sz4 && in_range && (off[1:0] == 2'd0);
    wr_ok     = (sz4 || sz8) && in_range && (off[2:0] == 3'd0) && writable;
    dec.legal = req_write ? wr_ok : (rd32 || dec.rd64);
  end
endmodule

// File: rtl/bootcon_regs.sv
module bootcon_regs
  import bootcon_pkg::*;
#(
  parameter int unsigned CPU_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      cfg_version,
  input  logic [31:0]      cfg_cpu_count,
  input  logic [31:0]      cfg_intr_hz,
  input  logic [63:0]      cfg_cpu_mhz,
  input  logic [63:0]      cfg_mem_size,
  input  logic [63:0]      cfg_kern_start,
  input  logic [63:0]      cfg_kern_end,
  input  logic [63:0]      cfg_entry,
  input  logic             acc,
  input  logic             wr,
  input  dec_t             dec,
  input  logic [63:0]      wval,
  input  logic             cin_valid,
  input  logic [7:0]       cin_data,
  output logic [63:0]      rd_data,
  output logic             val_err,
  output logic             cin_ready,
  output logic             cout_valid,
  output logic [7:0]       cout_data,
  output logic             disk_req,
  output logic [63:0]      disk_paddr,
  output logic [63:0]      disk_block,
  output logic [63:0]      disk_count,
  output logic             launch_valid,
  output logic [CPU_W-1:0] launch_cpu,
  output logic [63:0]      launch_ptr
);
  logic [31:0] ver_q, ncpu_q, intr_q, bootcpu_q;
  logic [63:0] mhz_q, mem_q, ks_q, ke_q, ent_q;
  logic [63:0] dunit_q, dcount_q, dpaddr_q, dblock_q, dop_q, bptr_q;
  logic [7:0]  cout_q;
  logic [63:0] word;
  logic wr_go, op_bad, boot_bad, commit;

  always_comb begin
    wr_go     = acc && wr;
    op_bad    = (dec.ix == IX_DOP) && (wval != DISK_RD_CODE);
    boot_bad  = (dec.ix == IX_BOOTCPU) && ((wval == '0) || ((wval >> CPU_W) != '0));
    val_err   = wr_go && (op_bad || boot_bad);
    commit    = wr_go && !val_err;
    cin_ready = acc && !wr && dec.rd64 && (dec.ix == IX_CIN);
  end

  always_comb begin
    case (dec.ix)
      IX_LAST:    word = 64'(BANK_BYTES - 1);
      IX_VER:     word = {32'b0, ver_q};
      IX_NCPU:    word = {32'b0, ncpu_q};
      IX_BOOTCPU: word = {32'b0, bootcpu_q};
      IX_INTR:    word = {32'b0, intr_q};
      IX_MHZ:     word = mhz_q;
      IX_MEMSZ:   word = mem_q;
      IX_KSTART:  word = ks_q;
      IX_KEND:    word = ke_q;
      IX_ENTRY:   word = ent_q;
      IX_DUNIT:   word = dunit_q;
      IX_DCOUNT:  word = dcount_q;
      IX_DPADDR:  word = dpaddr_q;
      IX_DBLOCK:  word = dblock_q;
      IX_DOP:     word = dop_q;
      IX_COUT:    word = {56'b0, cout_q};
      IX_BPTR:    word = bptr_q;
      default:    word = '0;
    endcase
    if (dec.rd64)
      rd_data = (dec.ix == IX_CIN) ? {56'b0, (cin_valid ? cin_data : 8'h00)} : word;
    else
      rd_data = {32'b0, (dec.hi_half ? word[63:32] : word[31:0])};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ver_q        <= cfg_version;
      ncpu_q       <= cfg_cpu_count;
      intr_q       <= cfg_intr_hz;
      mhz_q        <= cfg_cpu_mhz;
      mem_q        <= cfg_mem_size;
      ks_q         <= cfg_kern_start;
      ke_q         <= cfg_kern_end;
      ent_q        <= cfg_entry;
      bootcpu_q    <= '0;
      dunit_q      <= 64'd1;
      dcount_q     <= '0;
      dpaddr_q     <= '0;
      dblock_q     <= '0;
      dop_q        <= '0;
      bptr_q       <= '0;
      cout_q       <= '0;
      cout_valid   <= 1'b0;
      cout_data    <= '0;
      disk_req     <= 1'b0;
      launch_valid <= 1'b0;
      launch_cpu   <= '0;
    end else begin
      cout_valid   <= 1'b0;
      disk_req     <= 1'b0;
      launch_valid <= 1'b0;
      if (commit) begin
        case (dec.ix)
          IX_DUNIT:  dunit_q  <= wval;
          IX_DCOUNT: dcount_q <= wval;
          IX_DPADDR: dpaddr_q <= wval;
          IX_DBLOCK: dblock_q <= wval;
          IX_BPTR:   bptr_q   <= wval;
          IX_DOP: begin
            dop_q    <= wval;
            disk_req <= 1'b1;
          end
          IX_COUT: begin
            cout_q     <= wval[7:0];
            cout_data  <= wval[7:0];
            cout_valid <= 1'b1;
          end
          IX_BOOTCPU: begin
            bootcpu_q    <= wval[31:0];
            launch_cpu   <= wval[CPU_W-1:0];
            launch_valid <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign disk_paddr = dpaddr_q;
  assign disk_block = dblock_q;
  assign disk_count = dcount_q;
  assign launch_ptr = bptr_q;

  // R8
  launch_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_valid |-> (launch_cpu != '0));
  // R6
  disk_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disk_req |-> (dop_q == DISK_RD_CODE));
endmodule

// File: rtl/bootcon_top.sv
module bootcon_top
  import bootcon_pkg::*;
#(
  parameter int unsigned   AW    = 16,
  parameter logic [AW-1:0] BASE  = 16'h0400,
  parameter int unsigned   CPU_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      cfg_version,
  input  logic [31:0]      cfg_cpu_count,
  input  logic [31:0]      cfg_intr_hz,
  input  logic [63:0]      cfg_cpu_mhz,
  input  logic [63:0]      cfg_mem_size,
  input  logic [63:0]      cfg_kern_start,
  input  logic [63:0]      cfg_kern_end,
  input  logic [63:0]      cfg_entry,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [3:0]       req_size,
  input  logic [63:0]      req_wdata,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [63:0]      rsp_rdata,
  input  logic             cin_valid,
  input  logic [7:0]       cin_data,
  output logic             cin_ready,
  output logic             cout_valid,
  output logic [7:0]       cout_data,
  output logic             disk_req,
  output logic [63:0]      disk_paddr,
  output logic [63:0]      disk_block,
  output logic [63:0]      disk_count,
  output logic             launch_valid,
  output logic [CPU_W-1:0] launch_cpu,
  output logic [63:0]      launch_ptr
);
  dec_t        dec;
  logic        acc, val_err;
  logic [63:0] wval, rd_data;

  bootcon_decode #(.AW(AW), .BASE(BASE)) u_decode (
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .dec       (dec)
  );

  assign acc  = rst_n && req_valid && dec.legal;
  assign wval = dec.wide ? req_wdata : {32'b0, req_wdata[31:0]};

  bootcon_regs #(.CPU_W(CPU_W)) u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_version    (cfg_version),
    .cfg_cpu_count  (cfg_cpu_count),
    .cfg_intr_hz    (cfg_intr_hz),
    .cfg_cpu_mhz    (cfg_cpu_mhz),
    .cfg_mem_size   (cfg_mem_size),
    .cfg_kern_start (cfg_kern_start),
    .cfg_kern_end   (cfg_kern_end),
    .cfg_entry      (cfg_entry),
    .acc            (acc),
    .wr             (req_write),
    .dec            (dec),
    .wval           (wval),
    .cin_valid      (cin_valid),
    .cin_data       (cin_data),
    .rd_data        (rd_data),
    .val_err        (val_err),
    .cin_ready      (cin_ready),
    .cout_valid     (cout_valid),
    .cout_data      (cout_data),
    .disk_req       (disk_req),
    .disk_paddr     (disk_paddr),
    .disk_block     (disk_block),
    .disk_count     (disk_count),
    .launch_valid   (launch_valid),
    .launch_cpu     (launch_cpu),
    .launch_ptr     (launch_ptr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && (!dec.legal || val_err);
      rsp_rdata <= (acc && !req_write) ? rd_data : '0;
    end
  end

  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R10
  rsp_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R1
  err_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> !(disk_req || cout_valid || launch_valid));
  // R6
  disk_in_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disk_req |-> (rsp_valid && !rsp_err));
  // R7
  cout_in_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cout_valid |-> (rsp_valid && !rsp_err));
  // R5
  cin_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cin_ready |-> (req_valid && !req_write));
endmodule

// File: tb/test_bootcon_top.sv
module test_bootcon_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam logic [AW-1:0] BASE = 16'h0400;
  localparam int CPU_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] cfg_version = 32'h0002_0001, cfg_cpu_count = 32'd4, cfg_intr_hz = 32'd1024;
  logic [63:0] cfg_cpu_mhz = 64'd2000, cfg_mem_size = 64'h0000_0001_8000_0000;
  logic [63:0] cfg_kern_start = 64'h20_0000, cfg_kern_end = 64'h40_0000, cfg_entry = 64'h20_1000;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0] req_size = 4'd0;
  logic [63:0] req_wdata = '0;
  logic rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic cin_valid = 1'b0;
  logic [7:0] cin_data = 8'h00;
  logic cin_ready, cout_valid, disk_req, launch_valid;
  logic [7:0] cout_data;
  logic [63:0] disk_paddr, disk_block, disk_count, launch_ptr;
  logic [CPU_W-1:0] launch_cpu;

  int checks = 0, errors = 0;
  logic r_err, r_valid, r_cout, r_disk, r_launch, r_cinrdy;
  logic [63:0] r_data;

  bootcon_top #(.AW(AW), .BASE(BASE), .CPU_W(CPU_W)) i_bootcon_top (
    .clk(clk), .rst_n(rst_n),
    .cfg_version(cfg_version), .cfg_cpu_count(cfg_cpu_count), .cfg_intr_hz(cfg_intr_hz),
    .cfg_cpu_mhz(cfg_cpu_mhz), .cfg_mem_size(cfg_mem_size), .cfg_kern_start(cfg_kern_start),
    .cfg_kern_end(cfg_kern_end), .cfg_entry(cfg_entry),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .cin_valid(cin_valid), .cin_data(cin_data), .cin_ready(cin_ready),
    .cout_valid(cout_valid), .cout_data(cout_data), .disk_req(disk_req),
    .disk_paddr(disk_paddr), .disk_block(disk_block), .disk_count(disk_count),
    .launch_valid(launch_valid), .launch_cpu(launch_cpu), .launch_ptr(launch_ptr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [7:0]  off;
    logic [3:0]  sz;
    logic [63:0] wd;
    logic        err;
    logic [63:0] rd;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 4'd4, 64'h0, 1'b0, 64'd143, 4'd2},                  // R2 last offset
    '{1'b0, 8'h08, 4'd4, 64'h0, 1'b0, 64'h0002_0001, 4'd3},            // R3 version
    '{1'b0, 8'h10, 4'd4, 64'h0, 1'b0, 64'd4, 4'd3},                    // R3 cpu count
    '{1'b0, 8'h18, 4'd4, 64'h0, 1'b0, 64'd0, 4'd2},                    // R2 boot cpu
    '{1'b0, 8'h20, 4'd4, 64'h0, 1'b0, 64'd1024, 4'd3},                 // R3 intr clock
    '{1'b0, 8'h30, 4'd8, 64'h0, 1'b0, 64'd2000, 4'd4},                 // R4 mhz
    '{1'b0, 8'h38, 4'd8, 64'h0, 1'b0, 64'h0000_0001_8000_0000, 4'd4},  // R4 mem size
    '{1'b0, 8'h40, 4'd8, 64'h0, 1'b0, 64'h20_0000, 4'd4},              // R4 kern start
    '{1'b0, 8'h48, 4'd8, 64'h0, 1'b0, 64'h40_0000, 4'd4},              // R4 kern end
    '{1'b0, 8'h50, 4'd8, 64'h0, 1'b0, 64'h20_1000, 4'd4},              // R4 entry
    '{1'b0, 8'h58, 4'd8, 64'h0, 1'b0, 64'd1, 4'd2},                    // R2 disk unit
    '{1'b0, 8'h60, 4'd8, 64'h0, 1'b0, 64'd0, 4'd2},                    // R2 disk count
    '{1'b0, 8'h78, 4'd8, 64'h0, 1'b0, 64'd0, 4'd2},                    // R2 disk op
    '{1'b0, 8'h80, 4'd8, 64'h0, 1'b0, 64'd0, 4'd2},                    // R2 out char
    '{1'b0, 8'h88, 4'd8, 64'h0, 1'b0, 64'd0, 4'd2},                    // R2 boot pointer
    '{1'b0, 8'h00, 4'd8, 64'h0, 1'b1, 64'd0, 4'd4},                    // R4 8-byte below 0x28
    '{1'b0, 8'h3C, 4'd4, 64'h0, 1'b0, 64'd1, 4'd3},                    // R3 high half
    '{1'b0, 8'h38, 4'd4, 64'h0, 1'b0, 64'h8000_0000, 4'd3},            // R3 low half
    '{1'b0, 8'h90, 4'd4, 64'h0, 1'b1, 64'd0, 4'd3},                    // R3 out of range
    '{1'b0, 8'h44, 4'd8, 64'h0, 1'b1, 64'd0, 4'd4},                    // R4 misaligned
    '{1'b0, 8'h08, 4'd2, 64'h0, 1'b1, 64'd0, 4'd1},                    // R1 size 2 read
    '{1'b1, 8'h60, 4'd8, 64'h10, 1'b0, 64'd0, 4'd11},                  // R11 8-byte write
    '{1'b0, 8'h60, 4'd8, 64'h0, 1'b0, 64'h10, 4'd11},
    '{1'b1, 8'h68, 4'd4, 64'hFFFF_FFFF_DEAD_BEEF, 1'b0, 64'd0, 4'd11}, // R11 4-byte write
    '{1'b0, 8'h68, 4'd8, 64'h0, 1'b0, 64'hDEAD_BEEF, 4'd11},
    '{1'b1, 8'h08, 4'd8, 64'h77, 1'b1, 64'd0, 4'd9},                   // R9 read-only
    '{1'b0, 8'h08, 4'd4, 64'h0, 1'b0, 64'h0002_0001, 4'd9},
    '{1'b1, 8'h58, 4'd1, 64'h5, 1'b1, 64'd0, 4'd1},                    // R1 size 1 write
    '{1'b0, 8'h58, 4'd8, 64'h0, 1'b0, 64'd1, 4'd1},
    '{1'b1, 8'h58, 4'd8, 64'h3, 1'b0, 64'd0, 4'd9},                    // R9 writable
    '{1'b0, 8'h58, 4'd8, 64'h0, 1'b0, 64'd3, 4'd9}
  };

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic wr, logic [7:0] off, logic [3:0] sz, logic [63:0] wd);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = BASE + AW'(off);
    req_size  = sz;
    req_wdata = wd;
  endtask

  task automatic capture();
    r_valid  = rsp_valid;
    r_err    = rsp_err;
    r_data   = rsp_rdata;
    r_cout   = cout_valid;
    r_disk   = disk_req;
    r_launch = launch_valid;
  endtask

  task automatic access(logic wr, logic [7:0] off, logic [3:0] sz, logic [63:0] wd);
    @(negedge clk);
    drive(wr, off, sz, wd);
    #1 r_cinrdy = cin_ready;
    @(negedge clk);
    capture();
    req_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // reset: request during reset gets no response (R10, R2)
    @(negedge clk);
    drive(1'b1, 8'h80, 4'd8, 64'h55);
    repeat (3) @(negedge clk);
    check("R10 no response in reset", {63'b0, rsp_valid}, 64'd0);
    check("R2 no strobe in reset", {61'b0, cout_valid, disk_req, launch_valid}, 64'd0);
    req_valid = 1'b0;
    rst_n = 1'b1;
    cfg_version = 32'h0009_0009;   // R2: ignored after release

    foreach (VECS[i]) begin
      access(VECS[i].wr, VECS[i].off, VECS[i].sz, VECS[i].wd);
      check($sformatf("R%0d vec %0d valid", VECS[i].rq, i), {63'b0, r_valid}, 64'd1);
      check($sformatf("R%0d vec %0d err", VECS[i].rq, i), {63'b0, r_err}, {63'b0, VECS[i].err});
      check($sformatf("R%0d vec %0d data", VECS[i].rq, i), r_data, VECS[i].rd);
      check($sformatf("R%0d vec %0d strobes", VECS[i].rq, i),
            {61'b0, r_cout, r_disk, r_launch}, 64'd0);
    end

    // R10: response lasts one cycle
    @(negedge clk);
    check("R10 response one cycle", {63'b0, rsp_valid}, 64'd0);

    // R5: input character read
    cin_valid = 1'b1; cin_data = 8'h41;
    access(1'b0, 8'h28, 4'd8, 64'h0);
    check("R5 ready on char read", {63'b0, r_cinrdy}, 64'd1);
    check("R5 char data", r_data, 64'h41);
    access(1'b0, 8'h28, 4'd4, 64'h0);
    check("R3 4-byte char read no pop", {63'b0, r_cinrdy}, 64'd0);
    check("R3 4-byte char read zero", r_data, 64'h0);
    access(1'b0, 8'h30, 4'd8, 64'h0);
    check("R5 no ready on other read", {63'b0, r_cinrdy}, 64'd0);
    cin_valid = 1'b0;
    access(1'b0, 8'h28, 4'd8, 64'h0);
    check("R5 empty input reads zero", r_data, 64'h0);

    // R6: block set, then address and command back to back
    access(1'b1, 8'h70, 4'd8, 64'h55);
    cin_valid = 1'b1;
    @(negedge clk);
    drive(1'b1, 8'h68, 4'd8, 64'h2000);
    #1 check("R5 no ready on write", {63'b0, cin_ready}, 64'd0);
    @(negedge clk);
    check("R10 b2b first rsp", {62'b0, rsp_valid, rsp_err}, 64'd2);
    drive(1'b1, 8'h78, 4'd8, 64'h13);
    @(negedge clk);
    capture();
    req_valid = 1'b0;
    cin_valid = 1'b0;
    check("R6 disk strobe", {63'b0, r_disk}, 64'd1);
    check("R6 disk paddr", disk_paddr, 64'h2000);
    check("R6 disk block", disk_block, 64'h55);
    check("R6 disk count", disk_count, 64'h10);
    @(negedge clk);
    check("R6 disk one-shot", {63'b0, disk_req}, 64'd0);
    access(1'b1, 8'h78, 4'd8, 64'h14);
    check("R6 bad op err", {62'b0, r_err, r_disk}, 64'd2);
    access(1'b0, 8'h78, 4'd8, 64'h0);
    check("R6 bad op not stored", r_data, 64'h13);
    access(1'b1, 8'h78, 4'd0, 64'h13);
    check("R1 size 0 no disk", {62'b0, r_err, r_disk}, 64'd2);

    // R7: output character
    access(1'b1, 8'h80, 4'd8, 64'h1234_5641);
    check("R7 cout strobe", {63'b0, r_cout}, 64'd1);
    check("R7 cout data", {56'b0, cout_data}, 64'h41);
    access(1'b0, 8'h80, 4'd8, 64'h0);
    check("R7 cout readback", r_data, 64'h41);

    // R8: CPU launch
    access(1'b1, 8'h88, 4'd8, 64'hABC0);
    access(1'b1, 8'h18, 4'd4, 64'h2);
    check("R8 launch strobe", {62'b0, r_launch, r_err}, 64'd2);
    check("R8 launch cpu", {60'b0, launch_cpu}, 64'd2);
    check("R8 launch ptr", launch_ptr, 64'hABC0);
    access(1'b0, 8'h18, 4'd4, 64'h0);
    check("R8 boot cpu readback", r_data, 64'd2);
    access(1'b1, 8'h18, 4'd8, 64'h0);
    check("R8 index zero err", {62'b0, r_err, r_launch}, 64'd2);
    access(1'b1, 8'h18, 4'd8, 64'h10);
    check("R8 index too large err", {62'b0, r_err, r_launch}, 64'd2);
    access(1'b1, 8'h5C, 4'd4, 64'h9);
    check("R9 unaligned write err", {63'b0, r_err}, 64'd1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule